// File: doc/BRIEF.md
# Profile-Selected Frequency Word Loader

This block keeps four frequency tuning words, one for each profile, and feeds one of them, the active word, to a phase accumulator. Software-side logic writes each profile's word through a small write port. Each write lands in a shadow copy and leaves the running accumulator alone. Two select pins pick the profile. The more significant index bit comes from `sel_msb` and the less significant from `sel_lsb`.

A word reaches the accumulator by one of two commit paths. The first is a change of the profile selection: the newly chosen profile's shadow word becomes active with no other action. The second applies in single-tone mode only. A rising edge on the update strobe copies the current profile's edited shadow word into the active register. Outside single-tone mode the update line becomes an output, and the block drives a divided data clock on it with an output enable. The select pins and the strobe pass through a two-flop synchronizer. `tone_mode` and the write port are taken as synchronous to `clk`.

Top module: `ftw_profile_loader`

## Requirements
- R1: A synchronous active-high reset clears all four shadow words, the active word and the phase to zero; after reset every profile selects a zero word.
- R2: The profile index is `{sel_msb, sel_lsb}`: 0 selects profile 0, `sel_lsb`=1 alone selects profile 1, `sel_msb`=1 alone selects profile 2, both high select profile 3.
- R3: A write to any profile's word changes only its shadow copy; the active word holds its value until a commit happens.
- R4: A change of the synchronized profile index commits that profile's shadow word; `active_ftw` shows it after the third rising edge that samples the new pin levels, in either mode.
- R5: With `tone_mode` high, a low-to-high transition of `upd_strobe` commits the current profile's shadow word; `active_ftw` shows it after the third rising edge that samples the strobe high.
- R6: With `tone_mode` low, a strobe rise has no effect; a strobe held high commits only once, so later writes stay pending.
- R7: Every clock the phase advances by the active word modulo 2^FTW_W: the next phase equals the current phase plus the current `active_ftw`.
- R8: With `tone_mode` low, `pclk_oe` is high and `pclk_o` toggles every `PCLK_HALF` clocks (every clock by default); with `tone_mode` high, `pclk_oe` is low and `pclk_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| tone_mode | input | 1 | Single-tone mode; makes the update line an input |
| sel_lsb | input | 1 | Profile index bit 0 |
| sel_msb | input | 1 | Profile index bit 1 |
| upd_strobe | input | 1 | Frequency update strobe (rising edge, tone mode) |
| wr_en | input | 1 | Write enable for a shadow word |
| wr_prof | input | 2 | Profile whose shadow word is written |
| wr_word | input | FTW_W | Tuning word to write |
| pclk_o | output | 1 | Data clock driven when not in tone mode |
| pclk_oe | output | 1 | Output enable of the data clock |
| active_ftw | output | FTW_W | Tuning word currently added by the accumulator |
| phase_o | output | FTW_W | Accumulated phase |

## Verification
The select pins and the strobe each cross two synchronizer flops and one edge-detect compare. A commit therefore shows on `active_ftw` three rising edges after the pins are first sampled, and the phase step follows one edge after that. The driver records the cycle of every stimulus and queues each expected word with its due cycle. It also queues a hold value for the cycle just before. The monitor compares each item on the falling edge of its due cycle and flags any item whose cycle passed unchecked. Phase and data-clock checks sample one falling edge apart, which makes them one register away from their cause.

// File: rtl/ftw_loader_pkg.sv
package ftw_loader_pkg;
   localparam int PROF_CNT   = 4;
   localparam int PROF_IDX_W = $clog2(PROF_CNT);

   typedef logic [PROF_IDX_W-1:0] prof_idx_t;

   // index assembled from the two select pins, msb pin first
   function automatic prof_idx_t pack_idx(input logic msb, input logic lsb);
      return {msb, lsb};
   endfunction
endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q,
   output logic [W-1:0] q_prev
);
   if (STAGES < 2) begin : g_bad_stages
      $error("sync_chain: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("sync_chain: W must be at least 1");
   end

   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk) begin
      if (rst) begin
         stg    <= '0;
         q_prev <= '0;
      end else begin
         stg    <= {stg[STAGES-2:0], d};
         q_prev <= stg[STAGES-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/profile_bank.sv
module profile_bank #(
   parameter int FTW_W = 32,
   parameter int CNT   = 4,
   localparam int IW   = $clog2(CNT)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  logic [IW-1:0]    wr_idx,
   input  logic [FTW_W-1:0] wr_word,
   input  logic [IW-1:0]    rd_idx,
   output logic [FTW_W-1:0] rd_word
);
   if (CNT != (1 << IW)) begin : g_bad_cnt
      $error("profile_bank: CNT must be a power of two");
   end

   logic [FTW_W-1:0] shadow [CNT];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < CNT; i++) shadow[i] <= '0;
      end else if (wr_en) begin
         shadow[wr_idx] <= wr_word;
      end
   end

   assign rd_word = shadow[rd_idx];
endmodule

// File: rtl/phase_core.sv
module phase_core #(
   parameter int FTW_W = 32
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             commit,
   input  logic [FTW_W-1:0] next_ftw,
   output logic [FTW_W-1:0] ftw_q,
   output logic [FTW_W-1:0] phase_q
);
   always_ff @(posedge clk) begin
      if (rst) begin
         ftw_q   <= '0;
         phase_q <= '0;
      end else begin
         if (commit) ftw_q <= next_ftw;
         phase_q <= phase_q + ftw_q;   // wraps modulo 2^FTW_W
      end
   end
endmodule

// File: rtl/pclk_gen.sv
module pclk_gen #(
   parameter int HALF = 1
) (
   input  logic clk,
   input  logic rst,
   input  logic enable,
   output logic pclk
);
   if (HALF < 1) begin : g_bad_half
      $error("pclk_gen: HALF must be at least 1");
   end

   if (HALF == 1) begin : g_toggle
      always_ff @(posedge clk) begin
         if (rst || !enable) pclk <= 1'b0;
         else                pclk <= ~pclk;
      end
   end else begin : g_count
      localparam int CW = $clog2(HALF);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
         if (rst || !enable) begin
            pclk <= 1'b0;
            cnt  <= '0;
         end else if (cnt == CW'(HALF - 1)) begin
            pclk <= ~pclk;
            cnt  <= '0;
         end else begin
            cnt  <= cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/ftw_profile_loader.sv
module ftw_profile_loader
   import ftw_loader_pkg::*;
#(
   parameter int FTW_W       = 32,
   parameter int SYNC_STAGES = 2,
   parameter int PCLK_HALF   = 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tone_mode,
   input  logic             sel_lsb,
   input  logic             sel_msb,
   input  logic             upd_strobe,
   input  logic             wr_en,
   input  logic [1:0]       wr_prof,
   input  logic [FTW_W-1:0] wr_word,
   output logic             pclk_o,
   output logic             pclk_oe,
   output logic [FTW_W-1:0] active_ftw,
   output logic [FTW_W-1:0] phase_o
);
   if (PROF_IDX_W != 2) begin : g_bad_prof
      $error("ftw_profile_loader: two select pins need four profiles");
   end
   if (FTW_W < 8) begin : g_bad_ftw
      $error("ftw_profile_loader: FTW_W must be at least 8");
   end

   prof_idx_t        sel_raw, sel_now, sel_prev;
   logic             upd_now, upd_prev;
   logic             sel_changed, upd_rise, commit;
   logic [FTW_W-1:0] shadow_word;

   assign sel_raw = pack_idx(sel_msb, sel_lsb);

   sync_chain #(.W(PROF_IDX_W), .STAGES(SYNC_STAGES)) u_sel_sync (
      .clk(clk), .rst(rst), .d(sel_raw), .q(sel_now), .q_prev(sel_prev)
   );

   sync_chain #(.W(1), .STAGES(SYNC_STAGES)) u_upd_sync (
      .clk(clk), .rst(rst), .d(upd_strobe), .q(upd_now), .q_prev(upd_prev)
   );

   // two commit paths: selection change, or strobe edge in tone mode
   assign sel_changed = (sel_now != sel_prev);
   assign upd_rise    = upd_now & ~upd_prev & tone_mode;
   assign commit      = sel_changed | upd_rise;

   profile_bank #(.FTW_W(FTW_W), .CNT(PROF_CNT)) u_bank (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_prof),
      .wr_word(wr_word), .rd_idx(sel_now), .rd_word(shadow_word)
   );

   phase_core #(.FTW_W(FTW_W)) u_core (
      .clk(clk), .rst(rst), .commit(commit), .next_ftw(shadow_word),
      .ftw_q(active_ftw), .phase_q(phase_o)
   );

   pclk_gen #(.HALF(PCLK_HALF)) u_pclk (
      .clk(clk), .rst(rst), .enable(~tone_mode), .pclk(pclk_o)
   );

   assign pclk_oe = ~tone_mode;
endmodule

// File: rtl/ftw_loader_chk.sv
module ftw_loader_chk #(
   parameter int FTW_W = 32
) (
   input logic             clk,
   input logic             rst,
   input logic             tone_mode,
   input logic             pclk_o,
   input logic             commit,
   input logic [FTW_W-1:0] active_ftw,
   input logic [FTW_W-1:0] phase_o
);
   AST_RESET_CLEAR: assert property (@(posedge clk)
      $past(rst) |-> (active_ftw == '0 && phase_o == '0)); // R1

   AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> phase_o == $past(phase_o) + $past(active_ftw)); // R7

   AST_HOLD_NO_COMMIT: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(commit)) |-> $stable(active_ftw)); // R3

   AST_PCLK_QUIET: assert property (@(posedge clk) disable iff (rst)
      (tone_mode && $past(tone_mode)) |-> !pclk_o); // R8
endmodule

bind ftw_profile_loader ftw_loader_chk #(.FTW_W(FTW_W)) u_chk (
   .clk(clk), .rst(rst), .tone_mode(tone_mode), .pclk_o(pclk_o),
   .commit(commit), .active_ftw(active_ftw), .phase_o(phase_o)
);

// File: tb/tb_ftw_profile_loader.sv
module tb_ftw_profile_loader;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        tone_mode = 1'b1;
   logic        sel_lsb = 1'b0, sel_msb = 1'b0, upd_strobe = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_prof = '0;
   logic [31:0] wr_word = '0;
   logic        pclk_o, pclk_oe;
   logic [31:0] active_ftw, phase_o;

   int tests = 0, fails = 0, cyc = 0;
   bit done = 0;

   typedef struct {
      int          due;
      logic [31:0] val;
      string       req;
   } exp_t;
   exp_t q[$];

   localparam logic [31:0] W0 = 32'h0100_0000, W1 = 32'h0000_1234;
   localparam logic [31:0] W2 = 32'h4000_0001, W3 = 32'hF000_0000;
   localparam logic [31:0] W3B = 32'h0000_0777, W3C = 32'h0ABC_0000;

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   ftw_profile_loader dut (
      .clk(clk), .rst(rst), .tone_mode(tone_mode), .sel_lsb(sel_lsb),
      .sel_msb(sel_msb), .upd_strobe(upd_strobe), .wr_en(wr_en),
      .wr_prof(wr_prof), .wr_word(wr_word), .pclk_o(pclk_o),
      .pclk_oe(pclk_oe), .active_ftw(active_ftw), .phase_o(phase_o)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // monitor: pops expected active words on their due cycle
   always @(negedge clk) begin
      while (q.size() != 0 && q[0].due <= cyc) begin
         if (q[0].due == cyc) chk(q[0].req, active_ftw, q[0].val);
         else begin
            tests++; fails++;
            $display("FAIL %s: item due at %0d missed, actual %h expected %h",
                     q[0].req, q[0].due, active_ftw, q[0].val);
         end
         void'(q.pop_front());
      end
   end

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_ftw(int delay, logic [31:0] v, string req);
      exp_t e;
      e.due = cyc + delay; e.val = v; e.req = req;
      q.push_back(e);
   endtask

   task automatic drain();
      while (q.size() != 0) @(negedge clk);
      step(1);
   endtask

   task automatic wr(logic [1:0] p, logic [31:0] w);
      wr_en = 1'b1; wr_prof = p; wr_word = w;
      step(1);
      wr_en = 1'b0;
   endtask

   task automatic chk_phase(logic [31:0] inc, string req);
      logic [31:0] p0;
      p0 = phase_o;
      step(1);
      chk(req, phase_o, p0 + inc);
   endtask

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual hung expected completion");
         finish_run();
      end
   end

   initial begin
      logic a;
      step(3);
      rst = 1'b0;
      step(1);
      chk("R1 reset active", active_ftw, 32'h0);
      chk("R1 reset phase", phase_o, 32'h0);
      chk("R8 oe in tone mode", {31'b0, pclk_oe}, 32'h0);

      // R3: writes stay in shadow
      wr(2'd0, W0); wr(2'd1, W1); wr(2'd2, W2); wr(2'd3, W3);
      expect_ftw(3, 32'h0, "R3 write without commit");
      drain();

      // R5: strobe edge in tone mode commits profile 0
      upd_strobe = 1'b1;
      expect_ftw(2, 32'h0, "R5 before due");
      expect_ftw(3, W0, "R5 strobe commit");
      drain();
      upd_strobe = 1'b0;
      step(3);
      chk_phase(W0, "R7 phase step");

      // R4 / R2: selection changes commit without strobe
      sel_lsb = 1'b1;
      expect_ftw(2, W0, "R4 before due");
      expect_ftw(3, W1, "R4 R2 select profile 1");
      drain();
      sel_lsb = 1'b0; sel_msb = 1'b1;
      expect_ftw(3, W2, "R2 select profile 2");
      drain();
      sel_lsb = 1'b1;
      expect_ftw(3, W3, "R2 select profile 3");
      drain();
      chk_phase(W3, "R7 phase wrap a");
      chk_phase(W3, "R7 phase wrap b");

      // edit active profile, then commit by strobe
      wr(2'd3, W3B);
      expect_ftw(3, W3, "R3 edit pending");
      drain();
      upd_strobe = 1'b1;
      expect_ftw(3, W3B, "R5 edited word commit");
      drain();
      wr(2'd3, W3C);
      expect_ftw(4, W3B, "R6 held strobe no recommit");
      drain();
      upd_strobe = 1'b0;
      step(3);

      // not tone mode: data clock, strobe ignored
      tone_mode = 1'b0;
      step(2);
      chk("R8 oe out of tone mode", {31'b0, pclk_oe}, 32'h1);
      a = pclk_o;
      step(1);
      chk("R8 pclk toggles", {31'b0, pclk_o}, {31'b0, ~a});
      upd_strobe = 1'b1;
      expect_ftw(4, W3B, "R6 strobe ignored");
      drain();
      upd_strobe = 1'b0;
      step(3);
      sel_lsb = 1'b0; sel_msb = 1'b0;
      expect_ftw(3, W0, "R4 select in data mode");
      drain();
      sel_lsb = 1'b1; sel_msb = 1'b1;
      expect_ftw(3, W3C, "R4 pending shadow taken");
      drain();

      tone_mode = 1'b1;
      step(2);
      chk("R8 pclk low in tone mode", {31'b0, pclk_o}, 32'h0);
      chk("R8 oe low in tone mode", {31'b0, pclk_oe}, 32'h0);

      // second reset clears shadows
      rst = 1'b1;
      step(2);
      rst = 1'b0;
      step(1);
      chk("R1 second reset active", active_ftw, 32'h0);
      sel_lsb = 1'b0; sel_msb = 1'b0;
      expect_ftw(4, 32'h0, "R1 profile 0 cleared");
      drain();
      sel_lsb = 1'b1;
      expect_ftw(3, 32'h0, "R1 profile 1 cleared");
      drain();
      sel_lsb = 1'b0; sel_msb = 1'b1;
      expect_ftw(3, 32'h0, "R1 profile 2 cleared");
      drain();

      done = 1;
      finish_run();
   end
endmodule